// File: doc/BRIEF.md
# Crosspoint Switch with Staged Route Commit

This block is a single-bit digital crosspoint that connects 32 input lanes to 32 output lanes. Every output lane has its own selector that can pick any one input, so one input may feed a single output, a group of outputs or every output at the same time.

Route changes are staged. A host writes a 5-bit input number into the pending slot of one output per clock, naming that output with a 5-bit output index. These writes leave the live routing untouched. A one-cycle commit pulse then copies all pending slots into the live slots on the same clock edge, so the whole new map takes effect at once and no half-built route is ever seen at the outputs.

The data path is purely combinational from the live slots. A readback port returns the live selection of the output named by the index bus, which lets a host or a bench confirm the map.

Top module: `xpt_switch`

## Requirements
- R1: While `rst_n` is low and after it rises, every pending and live selection is 0, so each output follows input 0 and `live_sel` reads 0 for every index.
- R2: A clock edge with `wr_en` high stores `pend_sel` into the pending slot of output `out_idx` only; neither `data_out` nor `live_sel` changes until the next commit.
- R3: A clock edge with `commit` high loads every live slot from its pending slot on that same edge; all changed routes are visible together after that edge.
- R4: Each bit `data_out[o]` equals `data_in[k]`, where k is the live selection of output o, with no clock delay.
- R5: Several outputs, up to all 32, may hold the same live selection; each of them then carries that input bit.
- R6: When `wr_en` and `commit` are high on the same edge, the live slot takes the pending value held before that edge; the new write reaches the outputs only at a later commit.
- R7: `live_sel` shows, without clock delay, the live selection of the output given on `out_idx`.
- R8: A commit clears no pending slot, so a commit with no writes since the previous one leaves the routing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Store `pend_sel` into the pending slot of `out_idx` |
| out_idx | input | 5 | Output lane addressed for write and readback |
| pend_sel | input | 5 | Input number to stage |
| commit | input | 1 | Copy all pending slots to the live slots |
| data_in | input | 32 | Input lanes |
| data_out | output | 32 | Output lanes |
| live_sel | output | 5 | Live selection of output `out_idx` |

## Verification
Routes are tried as single one-to-one pairs taken from a vector table, as many outputs staged together and committed in one pulse, and as a full broadcast of one input. Each map is probed with alternating, walking-one and inverted data words, which tell a wrong selector apart from a stuck or swapped lane. The write-with-commit collision, a commit with nothing staged and a reset in mid-run separate correct staging from a design that lets writes leak into the live map or clears state it should keep.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned XPT_IN_DFLT  = 32;
  localparam int unsigned XPT_OUT_DFLT = 32;

  // Width of an index able to name n items (at least 1 bit).
  function automatic int unsigned idx_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction
endpackage

// File: rtl/xpt_sel_bank.sv
module xpt_sel_bank #(
  parameter int unsigned N_OUT  = 32,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned OIDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [OIDX_W-1:0]      wr_out,
  input  logic [SEL_W-1:0]       wr_val,
  input  logic                   commit,
  output logic [N_OUT*SEL_W-1:0] live_flat,
  output logic [SEL_W-1:0]       rd_val
);
  // Named events for the assertions
  logic [N_OUT-1:0] wr_hit;
  logic             commit_evt;

  function automatic logic [N_OUT-1:0] decode_out(input logic en,
                                                 input logic [OIDX_W-1:0] idx);
    logic [N_OUT-1:0] v;
    v = '0;
    for (int i = 0; i < N_OUT; i++)
      if (en && (idx == OIDX_W'(i))) v[i] = 1'b1;
    return v;
  endfunction

  assign wr_hit     = decode_out(wr_en, wr_out);
  assign commit_evt = commit;

  logic [SEL_W-1:0] pend_q [N_OUT];
  logic [SEL_W-1:0] live_q [N_OUT];

  for (genvar o = 0; o < N_OUT; o++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[o] <= '0;
        live_q[o] <= '0;
      end else begin
        if (wr_hit[o])  pend_q[o] <= wr_val;
        if (commit_evt) live_q[o] <= pend_q[o];
      end
    end
    assign live_flat[o*SEL_W +: SEL_W] = live_q[o];

    assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[o] |=> $stable(pend_q[o]));
    assert_live_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_evt |=> $stable(live_q[o]));
    assert_live_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit_evt |=> live_q[o] == $past(pend_q[o]));
    assert_collide_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_evt && wr_hit[o]) |=> (live_q[o] == $past(pend_q[o])) && (pend_q[o] == $past(wr_val)));
    assert_keep_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_evt && !wr_hit[o]) |=> pend_q[o] == $past(pend_q[o]));
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_OUT; i++)
      if (wr_out == OIDX_W'(i)) rd_val = live_q[i];
  end

  assert_one_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));
endmodule

// File: rtl/xpt_route.sv
module xpt_route #(
  parameter int unsigned N_IN  = 32,
  parameter int unsigned N_OUT = 32,
  parameter int unsigned SEL_W = 5
) (
  input  logic [N_IN-1:0]        data_in,
  input  logic [N_OUT*SEL_W-1:0] live_flat,
  output logic [N_OUT-1:0]       data_out
);
  function automatic logic pick_bit(input logic [N_IN-1:0] v,
                                    input logic [SEL_W-1:0] s);
    logic b;
    b = 1'b0;
    for (int i = 0; i < N_IN; i++)
      if (s == SEL_W'(i)) b = v[i];
    return b;
  endfunction

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane
    assign data_out[o] = pick_bit(data_in, live_flat[o*SEL_W +: SEL_W]);
  end
endmodule

// File: rtl/xpt_switch.sv
module xpt_switch #(
  parameter int unsigned N_IN   = xpt_pkg::XPT_IN_DFLT,
  parameter int unsigned N_OUT  = xpt_pkg::XPT_OUT_DFLT,
  localparam int unsigned SEL_W  = xpt_pkg::idx_width(N_IN),
  localparam int unsigned OIDX_W = xpt_pkg::idx_width(N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OIDX_W-1:0] out_idx,
  input  logic [SEL_W-1:0]  pend_sel,
  input  logic              commit,
  input  logic [N_IN-1:0]   data_in,
  output logic [N_OUT-1:0]  data_out,
  output logic [SEL_W-1:0]  live_sel
);
  logic [N_OUT*SEL_W-1:0] live_flat;

  xpt_sel_bank #(.N_OUT(N_OUT), .SEL_W(SEL_W), .OIDX_W(OIDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_out    (out_idx),
    .wr_val    (pend_sel),
    .commit    (commit),
    .live_flat (live_flat),
    .rd_val    (live_sel)
  );

  xpt_route #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_route (
    .data_in   (data_in),
    .live_flat (live_flat),
    .data_out  (data_out)
  );

  // Readback and lane 0 must agree on the same selector (R4, R7)
  assert_lane_rb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_idx == '0) |-> data_out[0] == data_in[live_sel]);
endmodule

// File: tb/tb_xpt_switch.sv
`timescale 1ns/1ps
module tb_xpt_switch;
  localparam int NI = 32;
  localparam int NO = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  out_idx = '0;
  logic [4:0]  pend_sel = '0;
  logic        commit = 1'b0;
  logic [31:0] data_in = '0;
  logic [31:0] data_out;
  logic [4:0]  live_sel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [4:0] pend_m [NO];
  logic [4:0] live_m [NO];

  // Vector table: {output, input} pairs, each staged, checked, then committed
  localparam logic [9:0] VEC [8] = '{
    {5'd0, 5'd31}, {5'd31, 5'd0}, {5'd5, 5'd17}, {5'd17, 5'd5},
    {5'd10, 5'd10}, {5'd22, 5'd3}, {5'd1, 5'd30}, {5'd30, 5'd1}
  };
  localparam logic [31:0] PATS [4] = '{
    32'hA5A5_5A5A, 32'h0000_0001, 32'h8000_0000, 32'h5A5A_A5A5
  };

  always #2.5 clk = ~clk;

  xpt_switch dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .out_idx(out_idx),
    .pend_sel(pend_sel), .commit(commit), .data_in(data_in),
    .data_out(data_out), .live_sel(live_sel)
  );

  task automatic model_reset();
    for (int i = 0; i < NO; i++) begin pend_m[i] = '0; live_m[i] = '0; end
  endtask

  task automatic cycle(input bit w, input logic [4:0] o, input logic [4:0] v, input bit c);
    @(negedge clk);
    wr_en = w; out_idx = o; pend_sel = v; commit = c;
    @(negedge clk);
    wr_en = 0; commit = 0;
    if (c) for (int i = 0; i < NO; i++) live_m[i] = pend_m[i];
    if (w) pend_m[o] = v;
  endtask

  task automatic chk_rb(input logic [4:0] o, input string tag);
    out_idx = o;
    #0.5;
    checks++;
    if (live_sel !== live_m[o]) begin
      failures++;
      $display("FAIL %s out=%0d live_sel actual=%0d expected=%0d", tag, o, live_sel, live_m[o]);
    end
  endtask

  task automatic chk_route(input logic [31:0] d, input string tag);
    logic [31:0] exp;
    data_in = d;
    #0.5;
    for (int i = 0; i < NO; i++) exp[i] = d[live_m[i]];
    checks++;
    if (data_out !== exp) begin
      failures++;
      $display("FAIL %s data_out actual=%h expected=%h", tag, data_out, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int p = 0; p < 4; p++) chk_route(PATS[p], tag);
    for (int i = 0; i < NO; i++) chk_rb(5'(i), tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk_rb(5'd7, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: all outputs follow input 0
    chk_route(32'h0000_0001, "R1 all follow in0");
    chk_route(32'hFFFF_FFFE, "R1 all follow in0");
    chk_all("R1 R7 reset map");

    // Vector table walk: R2 staging invisible, R3 commit, R4 route, R7 readback
    for (int k = 0; k < 8; k++) begin
      cycle(1, VEC[k][9:5], VEC[k][4:0], 0);
      chk_rb(VEC[k][9:5], "R2 staged not live");
      chk_route(32'hA5A5_5A5A, "R2 routing unchanged");
      cycle(0, 0, 0, 1);
      chk_rb(VEC[k][9:5], "R3 R7 committed readback");
      for (int p = 0; p < 4; p++) chk_route(PATS[p], "R4 routed data");
    end

    // R2/R3: many staged, one commit switches all together
    for (int i = 0; i < NO; i++) cycle(1, 5'(i), 5'(NO - 1 - i), 0);
    chk_all("R2 many staged, no change");
    cycle(0, 0, 0, 1);
    chk_all("R3 reversal committed together");
    for (int b = 0; b < NI; b++) chk_route(32'h1 << b, "R4 walking one");

    // R5: broadcast of input 7
    for (int i = 0; i < NO; i++) cycle(1, 5'(i), 5'd7, 0);
    cycle(0, 0, 0, 1);
    chk_route(32'h0000_0080, "R5 broadcast high");
    chk_route(32'hFFFF_FF7F, "R5 broadcast low");
    chk_rb(5'd19, "R5 broadcast readback");

    // R6: write and commit on the same edge
    cycle(1, 5'd3, 5'd9, 0);
    cycle(1, 5'd3, 5'd12, 1);
    chk_rb(5'd3, "R6 collision takes old pending");
    chk_route(32'h0000_0200, "R6 collision route");
    cycle(0, 0, 0, 1);
    chk_rb(5'd3, "R6 new value after later commit");
    chk_route(32'h0000_1000, "R6 later commit route");

    // R8: commit with nothing staged keeps routing
    cycle(0, 0, 0, 1);
    chk_all("R8 empty commit keeps map");
    cycle(0, 0, 0, 1);
    chk_rb(5'd3, "R8 second empty commit");

    // R1: reset mid-run clears all
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    chk_all("R1 reset clears live");
    cycle(0, 0, 0, 1);
    chk_all("R1 reset clears pending");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule